// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the sixteen architectural general registers of a 32-bit processor with operating modes, plus the status words tied to those modes. A 5-bit mode input selects which physical copy each register number reaches. The low eight registers and the program counter have one physical copy each. The fast-interrupt mode has its own copy of registers 8 to 12. Each privileged bank has its own stack pointer and link register. There is one current status word. Each exception mode has its own saved status word.

Two combinational read ports and one clocked write port serve normal instruction traffic. A dedicated entry port is used when an exception is taken. In a single clock it stores the return address into the target mode's link register and the interrupted status into that mode's saved status word. The current mode does not matter for this port. Exception sequencing, program-counter stepping and arithmetic sit outside the block.

Top module: `banked_regfile`

## Requirements
- R1: Registers 0 to 7 and register 15 have one physical copy. A value written in any mode reads back unchanged in every other mode.
- R2: Registers 8 to 12 read and write a private copy in the fast-interrupt mode (code 10001). Every other mode code shares one common copy.
- R3: Registers 13 and 14 have six physical pairs. User (10000) and system (11111) share one pair. Fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) each have a pair of their own.
- R4: Any mode code outside the seven listed in R3 selects the user bank for every register and for the saved status view.
- R5: Reads are combinational. A write lands on the clock edge, so a read of the written register in the same cycle returns the old value and the next cycle returns the new one.
- R6: The current status word has one copy. It is written through cpsr_we_i, is visible on the next cycle, and reads the same in every mode.
- R7: Each of the five exception modes has its own saved status word. spsr_o shows the word of the current mode, and spsr_we_i writes only that word.
- R8: In user, system or unlisted modes, spsr_o shows the current status word, and a saved status write changes no stored state.
- R9: When exc_en_i is high, exc_lr_i is stored into register 14 of the bank selected by exc_mode_i. In the same edge, exc_spsr_i is stored into that bank's saved status word. The current mode plays no part in this.
- R10: When the entry port and the normal ports target the same physical register or saved status word in one cycle, the entry port's value is kept. Writes to different physical locations in that cycle both take effect.
- R11: An active-low asynchronous reset clears every general register, the current status word and every saved status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current operating mode code |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | DW | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | DW | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Write register number |
| wr_data_i | input | DW | Write data |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_data_i | input | DW | Current status write data |
| cpsr_o | output | DW | Current status word |
| spsr_we_i | input | 1 | Saved status write enable (current mode) |
| spsr_data_i | input | DW | Saved status write data |
| spsr_o | output | DW | Saved status view for the current mode |
| exc_en_i | input | 1 | Exception entry strobe |
| exc_mode_i | input | 5 | Target mode of the exception |
| exc_lr_i | input | DW | Return address for the target link register |
| exc_spsr_i | input | DW | Status word to save for the target mode |

## Verification
A wrong bank mapping appears at the read ports as soon as the mode input changes. A register that should be private returns a neighbour's value, or a shared one returns a stale copy, in the same cycle with no clock needed. A misrouted write or a lost priority is visible one cycle after the offending edge, when the affected location is read in the mode that owns it. A corrupted saved status word shows on spsr_o the first cycle the owning mode is selected.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int NUM_ARCH  = 16;
  localparam int AW        = $clog2(NUM_ARCH);
  localparam int NUM_BANKS = 6;
  localparam int BW        = $clog2(NUM_BANKS);
  localparam int LOW_CNT   = 8;
  localparam int HI_FIRST  = 8;
  localparam int HI_LAST   = 12;
  localparam int HI_CNT    = HI_LAST - HI_FIRST + 1;
  localparam int SP_NUM    = 13;
  localparam int LR_NUM    = 14;
  localparam int PC_NUM    = 15;
  localparam int HI_FIQ_BASE = LOW_CNT + HI_CNT;
  localparam int PAIR_BASE   = HI_FIQ_BASE + HI_CNT;
  localparam int PC_PHYS     = PAIR_BASE + 2 * NUM_BANKS;
  localparam int NUM_PHYS    = PC_PHYS + 1;
  localparam int PW          = $clog2(NUM_PHYS);

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  typedef enum logic [BW-1:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;
endpackage

// File: rtl/bank_decode.sv
module bank_decode
  import bank_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o,
  output logic       has_spsr_o
);
  always_comb begin
    unique case (mode_i)
      M_FIQ:   bank_o = BK_FIQ;
      M_IRQ:   bank_o = BK_IRQ;
      M_SVC:   bank_o = BK_SVC;
      M_ABT:   bank_o = BK_ABT;
      M_UND:   bank_o = BK_UND;
      default: bank_o = BK_USR; // user, system, unlisted
    endcase
    has_spsr_o = (bank_o != BK_USR);
  end
endmodule

// File: rtl/phys_map.sv
module phys_map
  import bank_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  bank_e         bank_i,
  output logic [PW-1:0] idx_o
);
  int unsigned a, v;
  always_comb begin
    a = int'(addr_i);
    if (a < LOW_CNT)
      v = a;
    else if (a <= HI_LAST)
      v = (bank_i == BK_FIQ) ? HI_FIQ_BASE + (a - HI_FIRST) : a;
    else if (a == PC_NUM)
      v = PC_PHYS;
    else
      v = PAIR_BASE + 2 * int'(bank_i) + (a - SP_NUM);
    idx_o = PW'(v);
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    mode_i,
  input  logic [AW-1:0] rd_a_addr_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cpsr_we_i,
  input  logic [DW-1:0] cpsr_data_i,
  output logic [DW-1:0] cpsr_o,
  input  logic          spsr_we_i,
  input  logic [DW-1:0] spsr_data_i,
  output logic [DW-1:0] spsr_o,
  input  logic          exc_en_i,
  input  logic [4:0]    exc_mode_i,
  input  logic [DW-1:0] exc_lr_i,
  input  logic [DW-1:0] exc_spsr_i
);
  localparam int NSP = NUM_BANKS - 1;

  bank_e         cur_bank, exc_bank;
  logic          cur_has_spsr, exc_has_spsr;
  logic [PW-1:0] rd_a_idx, rd_b_idx, wr_idx, exc_lr_idx;

  bank_decode u_dec_cur (.mode_i(mode_i),     .bank_o(cur_bank), .has_spsr_o(cur_has_spsr));
  bank_decode u_dec_exc (.mode_i(exc_mode_i), .bank_o(exc_bank), .has_spsr_o(exc_has_spsr));

  phys_map u_map_a  (.addr_i(rd_a_addr_i),      .bank_i(cur_bank), .idx_o(rd_a_idx));
  phys_map u_map_b  (.addr_i(rd_b_addr_i),      .bank_i(cur_bank), .idx_o(rd_b_idx));
  phys_map u_map_w  (.addr_i(wr_addr_i),        .bank_i(cur_bank), .idx_o(wr_idx));
  phys_map u_map_lr (.addr_i(AW'(LR_NUM)),      .bank_i(exc_bank), .idx_o(exc_lr_idx));

  logic [DW-1:0] gpr_rd  [NUM_PHYS];
  logic [DW-1:0] spsr_rd [NSP];

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_gpr
    logic [DW-1:0] q;
    logic          exc_hit, wr_hit;
    assign exc_hit = exc_en_i && (exc_lr_idx == PW'(p));
    assign wr_hit  = wr_en_i  && (wr_idx     == PW'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (exc_hit) q <= exc_lr_i;   // entry port wins
      else if (wr_hit)  q <= wr_data_i;
    end
    assign gpr_rd[p] = q;
  end

  for (genvar b = 0; b < NSP; b++) begin : g_spsr
    logic [DW-1:0] q;
    logic          exc_hit, wr_hit;
    assign exc_hit = exc_en_i  && exc_has_spsr && (int'(exc_bank) == b + 1);
    assign wr_hit  = spsr_we_i && cur_has_spsr && (int'(cur_bank) == b + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (exc_hit) q <= exc_spsr_i;
      else if (wr_hit)  q <= spsr_data_i;
    end
    assign spsr_rd[b] = q;
  end

  logic [DW-1:0] cpsr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cpsr_q <= '0;
    else if (cpsr_we_i) cpsr_q <= cpsr_data_i;
  end

  logic [BW-1:0] sp_sel;
  assign sp_sel = BW'(cur_bank) - BW'(1);

  assign rd_a_data_o = gpr_rd[rd_a_idx];
  assign rd_b_data_o = gpr_rd[rd_b_idx];
  assign cpsr_o      = cpsr_q;
  assign spsr_o      = cur_has_spsr ? spsr_rd[sp_sel] : cpsr_q;
endmodule

// File: rtl/regfile_sva.sv
module regfile_sva
  import bank_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    mode_i,
  input logic [AW-1:0] rd_a_addr_i,
  input logic [DW-1:0] rd_a_data_o,
  input logic [AW-1:0] rd_b_addr_i,
  input logic [DW-1:0] rd_b_data_o,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          cpsr_we_i,
  input logic [DW-1:0] cpsr_data_i,
  input logic [DW-1:0] cpsr_o,
  input logic          spsr_we_i,
  input logic [DW-1:0] spsr_data_i,
  input logic [DW-1:0] spsr_o,
  input logic          exc_en_i,
  input logic [4:0]    exc_mode_i,
  input logic [DW-1:0] exc_lr_i,
  input logic [DW-1:0] exc_spsr_i
);
  logic cur_unpriv, exc_priv;
  assign cur_unpriv = (mode_i == M_USR) || (mode_i == M_SYS);
  assign exc_priv   = (exc_mode_i == M_FIQ) || (exc_mode_i == M_IRQ) ||
                      (exc_mode_i == M_SVC) || (exc_mode_i == M_ABT) ||
                      (exc_mode_i == M_UND);

  // R1: shared registers visible in any mode after a write
  a_r1_shared_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !exc_en_i && (wr_addr_i < AW'(LOW_CNT) || wr_addr_i == AW'(PC_NUM)) &&
     rd_b_addr_i == wr_addr_i)
    |=> ($stable(rd_b_addr_i) -> rd_b_data_o == $past(wr_data_i)));

  // R5: write visible on next cycle in the same mode
  a_r5_write_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !exc_en_i && rd_a_addr_i == wr_addr_i)
    |=> (($stable(mode_i) && $stable(rd_a_addr_i)) -> rd_a_data_o == $past(wr_data_i)));

  // R6: current status write lands next cycle
  a_r6_cpsr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_we_i |=> cpsr_o == $past(cpsr_data_i));

  // R8: unprivileged banks see the current status word
  a_r8_spsr_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_unpriv |-> spsr_o == cpsr_o);

  // R8: saved status write in unprivileged mode leaves the current word alone
  a_r8_spsr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spsr_we_i && cur_unpriv && !cpsr_we_i) |=> $stable(cpsr_o));

  // R9, R10: entry port value reaches the target link register
  a_r9_exc_lr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && exc_priv)
    |=> ((mode_i == $past(exc_mode_i) && rd_a_addr_i == AW'(LR_NUM))
         -> rd_a_data_o == $past(exc_lr_i)));

  // R9, R10: entry port value reaches the target saved status word
  a_r9_exc_spsr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && exc_priv)
    |=> (mode_i == $past(exc_mode_i) -> spsr_o == $past(exc_spsr_i)));
endmodule

bind banked_regfile regfile_sva #(.DW(DW)) sva_i (.*);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  import bank_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int WD_CYCLES = 20000;

  logic          clk = 0, rst_n = 0;
  logic [4:0]    mode = M_USR, exc_mode = M_USR;
  logic [3:0]    rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 0, cpsr_we = 0, spsr_we = 0, exc_en = 0;
  logic [DW-1:0] cpsr_data = '0, cpsr, spsr_data = '0, spsr, exc_lr = '0, exc_spsr = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile #(.DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .rd_a_addr_i(rd_a_addr), .rd_a_data_o(rd_a_data),
    .rd_b_addr_i(rd_b_addr), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cpsr_we_i(cpsr_we), .cpsr_data_i(cpsr_data), .cpsr_o(cpsr),
    .spsr_we_i(spsr_we), .spsr_data_i(spsr_data), .spsr_o(spsr),
    .exc_en_i(exc_en), .exc_mode_i(exc_mode), .exc_lr_i(exc_lr), .exc_spsr_i(exc_spsr));

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk); mode = m; wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [4:0] m, input logic [3:0] a,
                    input logic [DW-1:0] exp);
    mode = m; rd_a_addr = a; rd_b_addr = a; #1;
    check({tag, " port A"}, rd_a_data, exp);
    check({tag, " port B"}, rd_b_data, exp);
  endtask

  task automatic rd_spsr(input string tag, input logic [4:0] m, input logic [DW-1:0] exp);
    mode = m; #1; check(tag, spsr, exp);
  endtask

  task automatic test_reset;  // R11
    @(negedge clk);
    for (int r = 0; r < 16; r++) rd("R11 reset gpr", M_USR, 4'(r), '0);
    rd("R11 reset fiq r8", M_FIQ, 4'd8, '0);
    check("R11 reset cpsr", cpsr, '0);
    rd_spsr("R11 reset spsr svc", M_SVC, '0);
  endtask

  task automatic test_shared;  // R1
    wr(M_USR, 4'd3, 32'hA5A5_0003);
    rd("R1 r3 in fiq", M_FIQ, 4'd3, 32'hA5A5_0003);
    rd("R1 r3 in und", M_UND, 4'd3, 32'hA5A5_0003);
    wr(M_IRQ, 4'd15, 32'h0000_1234);
    rd("R1 pc in user", M_USR, 4'd15, 32'h0000_1234);
    rd("R1 pc in fiq", M_FIQ, 4'd15, 32'h0000_1234);
  endtask

  task automatic test_fiq_hi;  // R2
    wr(M_USR, 4'd9, 32'h1111_0009);
    wr(M_FIQ, 4'd9, 32'hF1F1_0009);
    wr(M_SVC, 4'd12, 32'h2222_000C);
    rd("R2 r9 user copy", M_USR, 4'd9, 32'h1111_0009);
    rd("R2 r9 fiq copy", M_FIQ, 4'd9, 32'hF1F1_0009);
    rd("R2 r9 svc shares user", M_SVC, 4'd9, 32'h1111_0009);
    rd("R2 r12 sys shares", M_SYS, 4'd12, 32'h2222_000C);
    rd("R2 r12 fiq private", M_FIQ, 4'd12, '0);
  endtask

  logic [4:0] mlist [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};

  task automatic test_pairs;  // R3
    for (int i = 0; i < 7; i++) begin
      wr(mlist[i], 4'd13, 32'h5000_0000 + i);
      wr(mlist[i], 4'd14, 32'h6000_0000 + i);
    end
    for (int i = 0; i < 7; i++) begin
      int k = (i == 0) ? 6 : i;
      rd("R3 sp bank", mlist[i], 4'd13, 32'h5000_0000 + k);
      rd("R3 lr bank", mlist[i], 4'd14, 32'h6000_0000 + k);
    end
  endtask

  task automatic test_unlisted;  // R4
    rd("R4 code 00000 sp", 5'b00000, 4'd13, 32'h5000_0006);
    rd("R4 code 10100 lr", 5'b10100, 4'd14, 32'h6000_0006);
    rd("R4 code 11110 r9", 5'b11110, 4'd9, 32'h1111_0009);
  endtask

  task automatic test_timing;  // R5
    wr(M_USR, 4'd5, 32'h0000_0055);
    @(negedge clk);
    mode = M_USR; rd_a_addr = 4'd5; rd_b_addr = 4'd5;
    wr_en = 1; wr_addr = 4'd5; wr_data = 32'hDEAD_0005; #1;
    check("R5 same-cycle old A", rd_a_data, 32'h0000_0055);
    check("R5 same-cycle old B", rd_b_data, 32'h0000_0055);
    @(posedge clk); #1;
    check("R5 next-cycle new", rd_a_data, 32'hDEAD_0005);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic test_cpsr;  // R6
    @(negedge clk); cpsr_we = 1; cpsr_data = 32'h6000_00D3; #1;
    check("R6 cpsr old same cycle", cpsr, '0);
    @(negedge clk); cpsr_we = 0;
    mode = M_FIQ; #1; check("R6 cpsr in fiq", cpsr, 32'h6000_00D3);
    mode = M_USR; #1; check("R6 cpsr in user", cpsr, 32'h6000_00D3);
  endtask

  task automatic test_spsr;  // R7, R8
    @(negedge clk); mode = M_SVC; spsr_we = 1; spsr_data = 32'h0000_0A13;
    @(negedge clk); mode = M_IRQ; spsr_data = 32'h0000_0B12;
    @(negedge clk); spsr_we = 0;
    rd_spsr("R7 svc spsr", M_SVC, 32'h0000_0A13);
    rd_spsr("R7 irq spsr", M_IRQ, 32'h0000_0B12);
    rd_spsr("R7 abt spsr untouched", M_ABT, '0);
    rd_spsr("R8 user view is cpsr", M_USR, 32'h6000_00D3);
    rd_spsr("R8 unlisted view is cpsr", 5'b00011, 32'h6000_00D3);
    @(negedge clk); mode = M_SYS; spsr_we = 1; spsr_data = 32'hBAD0_BAD0;
    @(negedge clk); spsr_we = 0; #1;
    check("R8 sys write leaves cpsr", cpsr, 32'h6000_00D3);
    rd_spsr("R8 sys write leaves svc", M_SVC, 32'h0000_0A13);
    rd_spsr("R8 sys write leaves irq", M_IRQ, 32'h0000_0B12);
    rd_spsr("R8 sys view still cpsr", M_SYS, 32'h6000_00D3);
  endtask

  task automatic test_exc;  // R9
    @(negedge clk); mode = M_USR;
    exc_en = 1; exc_mode = M_SVC; exc_lr = 32'h4000_2008; exc_spsr = 32'h0000_0010;
    @(negedge clk); exc_en = 0;
    rd("R9 svc lr", M_SVC, 4'd14, 32'h4000_2008);
    rd_spsr("R9 svc spsr", M_SVC, 32'h0000_0010);
    rd("R9 svc sp untouched", M_SVC, 4'd13, 32'h5000_0003);
    rd("R9 user lr untouched", M_USR, 4'd14, 32'h6000_0006);
    rd_spsr("R9 irq spsr untouched", M_IRQ, 32'h0000_0B12);
  endtask

  task automatic test_priority;  // R10
    @(negedge clk); mode = M_ABT;
    wr_en = 1; wr_addr = 4'd14; wr_data = 32'hBBBB_BBBB;
    spsr_we = 1; spsr_data = 32'hCCCC_CCCC;
    exc_en = 1; exc_mode = M_ABT; exc_lr = 32'h1234_5678; exc_spsr = 32'h0000_0017;
    @(negedge clk); wr_en = 0; spsr_we = 0; exc_en = 0;
    rd("R10 lr entry wins", M_ABT, 4'd14, 32'h1234_5678);
    rd_spsr("R10 spsr entry wins", M_ABT, 32'h0000_0017);
    @(negedge clk); mode = M_USR;
    wr_en = 1; wr_addr = 4'd2; wr_data = 32'h0000_0222;
    exc_en = 1; exc_mode = M_UND; exc_lr = 32'h0000_0DDD; exc_spsr = 32'h0000_001B;
    @(negedge clk); wr_en = 0; exc_en = 0;
    rd("R10 disjoint normal write", M_USR, 4'd2, 32'h0000_0222);
    rd("R10 disjoint entry write", M_UND, 4'd14, 32'h0000_0DDD);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_shared();
    test_fiq_hi();
    test_pairs();
    test_unlisted();
    test_timing();
    test_cpsr();
    test_spsr();
    test_exc();
    test_priority();
    done = 1;
    report();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule